// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a 16-bit CPU core. Each source carries a two-bit control field that either switches it off or places it in one of three priority tiers. A rising edge on a source line latches a pending bit. Among the pending, enabled sources, the controller picks one winner: the highest tier first, then the lowest source index inside that tier. It presents a single request to the CPU, together with the winner's index and tier.

Requests reach the CPU only while the global interrupt enable is set. That enable is bit 0 of the CPU flag register. The CPU drives it through enable and disable instruction strobes, through direct flag-register loads, and through the flag value restored on return-from-interrupt. When the CPU acknowledges a request, the controller clears the global enable and the winner's pending bit. Stacking of the program counter and flags is left to the CPU. Vector table contents are also outside this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, gie_o, irq_o and pend_o are all zero, and vec_o and lvl_o read 0.
- R2: A 0-to-1 transition on src_i[i] sets pend_o[i] at the next clock edge. A line held high does not set the bit again once it has been cleared.
- R3: With clr_we_i high, every 1 in clr_mask_i clears the matching pending bit. If a new rising edge arrives on the same source in that same cycle, the bit stays set.
- R4: Source i has its control field at cfg_i[2i+1:2i], loaded whole when cfg_we_i is high. 00 disables the source, and 01, 10 and 11 select tiers 1, 2 and 3. A disabled source still latches its pending bit but never raises irq_o.
- R5: A pending, enabled source in a higher tier wins over every source in a lower tier, whatever their indices. lvl_o reports the winner's tier as 1, 2 or 3.
- R6: When several pending sources share the top tier, the lowest index wins.
- R7: irq_o is 1 only when gie_o is 1 and at least one enabled source is pending. A change in either one shows on irq_o at the same clock edge.
- R8: ei_i, or flag_we_i with flag_ie_i=1, sets gie_o. di_i, or flag_we_i with flag_ie_i=0, clears it. In each case the change appears one edge later.
- R9: iret_i loads gie_o from iret_ie_i, the enable bit of the restored flags, whether that bit is 0 or 1.
- R10: ack_i while irq_o=1 clears gie_o and the pending bit of the source shown on vec_o. ack_i while irq_o=0 has no effect.
- R11: If a set event and a clear event reach the global enable in the same cycle, gie_o becomes 0.
- R12: While irq_o stays 1, vec_o and lvl_o hold, even if a higher-priority source becomes pending. If the held source stops being pending or enabled, irq_o drops for one cycle. The controller then arbitrates again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw interrupt lines, edge captured |
| cfg_we_i | input | 1 | Load all control fields |
| cfg_i | input | 2*NUM_SRC | Control fields, two bits per source |
| clr_we_i | input | 1 | Write-1-to-clear strobe for pending bits |
| clr_mask_i | input | NUM_SRC | Pending bits to clear |
| ei_i | input | 1 | Enable-interrupt instruction strobe |
| di_i | input | 1 | Disable-interrupt instruction strobe |
| flag_we_i | input | 1 | Flag register load strobe |
| flag_ie_i | input | 1 | Bit 0 of the loaded flag value |
| iret_i | input | 1 | Return-from-interrupt flag restore strobe |
| iret_ie_i | input | 1 | Bit 0 of the restored flags |
| ack_i | input | 1 | CPU acknowledge of the current request |
| irq_o | output | 1 | Request to the CPU |
| vec_o | output | IDX_W | Index of the presented source |
| lvl_o | output | 2 | Tier of the presented source |
| gie_o | output | 1 | Global interrupt enable (flag bit 0) |
| pend_o | output | NUM_SRC | Pending bits |

## Verification
A wrong pending bit shows on pend_o at the edge after the bad update. It also shows on irq_o and vec_o once that source is enabled and its tier is the highest one present. A wrong global-enable value shows on gie_o and irq_o one edge after the strobe that caused it. A flaw in the hold register shows as vec_o changing while irq_o stays high, or as an acknowledge that clears the wrong pending bit. The bench sees each of these within one or two cycles, because every state element in the block drives a port either directly or through the arbiter.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    LVL_OFF = 2'b00,
    LVL_1   = 2'b01,
    LVL_2   = 2'b10,
    LVL_3   = 2'b11
  } lvl_e;

  localparam int unsigned NUM_LVL = 3;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_n_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q, rise;

  assign rise     = src_i & ~src_q;
  // new edge outranks a same-cycle clear so no event is lost
  assign pend_n_o = (pend_o & ~clr_i) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      pend_o <= pend_n_o;
    end
  end

  a_r2_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~rise) != '0) |=> ((pend_o & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/irq_gie.sv
module irq_gie (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_n_o,
  output logic gie_o
);
  always_comb begin
    gie_n_o = gie_o;
    if (set_i) gie_n_o = 1'b1;
    if (clr_i) gie_n_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gie_o <= 1'b0;
    else         gie_o <= gie_n_o;
  end

  a_r11_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !gie_o);

  a_r8_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> gie_o);

  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(gie_o));
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      pend_i,
  input  logic [NUM_SRC-1:0][1:0] ctrl_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [1:0]              lvl_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [NUM_SRC-1:0] match;
    logic               hit;
    logic [IDX_W-1:0]   idx;
    always_comb begin
      for (int i = 0; i < NUM_SRC; i++)
        match[i] = pend_i[i] && (ctrl_i[i] == 2'(g + 1));
      hit = |match;
      idx = '0;
      // descending scan leaves the lowest matching index
      for (int i = NUM_SRC - 1; i >= 0; i--)
        if (match[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_OFF;
    if (g_lvl[0].hit) begin valid_o = 1'b1; idx_o = g_lvl[0].idx; lvl_o = LVL_1; end
    if (g_lvl[1].hit) begin valid_o = 1'b1; idx_o = g_lvl[1].idx; lvl_o = LVL_2; end
    if (g_lvl[2].hit) begin valid_o = 1'b1; idx_o = g_lvl[2].idx; lvl_o = LVL_3; end
  end

  a_r6_winner_real: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && (ctrl_i[idx_o] == lvl_o) && (lvl_o != LVL_OFF)));

  a_r5_top_tier_empty_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && lvl_o != LVL_3) |-> !g_lvl[2].hit);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned CFG_W  = 2 * NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               flag_we_i,
  input  logic               flag_ie_i,
  input  logic               iret_i,
  input  logic               iret_ie_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic [1:0]         lvl_o,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0][1:0] ctrl_q, ctrl_n;
  logic [NUM_SRC-1:0]      pend_n, clr_all, ack_mask;
  logic                    gie_n, gie_set, gie_clr, ack_hit;
  logic                    win_valid;
  logic [IDX_W-1:0]        win_idx, vec_n;
  logic [1:0]              win_lvl, lvl_n;
  logic                    irq_n, hold_ok;

  assign ctrl_n = cfg_we_i ? cfg_i : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_n;
  end

  assign ack_hit  = ack_i & irq_o;
  assign ack_mask = ack_hit ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << vec_o) : '0;
  assign clr_all  = (clr_we_i ? clr_mask_i : '0) | ack_mask;

  irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .clr_i    (clr_all),
    .pend_n_o (pend_n),
    .pend_o   (pend_o)
  );

  assign gie_set = ei_i | (flag_we_i & flag_ie_i) | (iret_i & iret_ie_i);
  assign gie_clr = di_i | ack_hit | (flag_we_i & ~flag_ie_i) | (iret_i & ~iret_ie_i);

  irq_gie u_gie (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (gie_set),
    .clr_i   (gie_clr),
    .gie_n_o (gie_n),
    .gie_o   (gie_o)
  );

  // arbitrate on next-state so request, pending and enable move together
  irq_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_n),
    .ctrl_i  (ctrl_n),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  assign hold_ok = irq_o & ~ack_hit & gie_n & pend_n[vec_o] & (ctrl_n[vec_o] != LVL_OFF);

  always_comb begin
    vec_n = vec_o;
    lvl_n = lvl_o;
    if (irq_o) begin
      irq_n = hold_ok;  // a broken hold drops the line for one cycle
    end else begin
      irq_n = gie_n & win_valid;
      if (win_valid) begin
        vec_n = win_idx;
        lvl_n = win_lvl;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      vec_o <= '0;
      lvl_o <= LVL_OFF;
    end else begin
      irq_o <= irq_n;
      vec_o <= vec_n;
      lvl_o <= lvl_n;
    end
  end

  a_r7_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_o);

  a_r7_irq_src_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o[vec_o] && ctrl_q[vec_o] != LVL_OFF));

  a_r12_vec_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_n) |=> ($stable(vec_o) && $stable(lvl_o)));

  a_r10_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (!gie_o && !irq_o && !pend_o[$past(vec_o)]));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0, clr_mask = '0, pend;
  logic [15:0]  cfg = '0;
  logic         cfg_we = 0, clr_we = 0, ei = 0, di = 0, flag_we = 0, flag_ie = 0;
  logic         iret = 0, iret_ie = 0, ack = 0;
  logic         irq, gie;
  logic [2:0]   vec;
  logic [1:0]   lvl;
  int           n_cmp = 0, n_bad = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N)) u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .cfg_we_i(cfg_we), .cfg_i(cfg),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .ei_i(ei), .di_i(di),
    .flag_we_i(flag_we), .flag_ie_i(flag_ie), .iret_i(iret), .iret_ie_i(iret_ie),
    .ack_i(ack), .irq_o(irq), .vec_o(vec), .lvl_o(lvl), .gie_o(gie), .pend_o(pend)
  );

  // {cfg[15:0], src mask[7:0], 0, irq, lvl[1:0], 0, vec[2:0]}
  localparam logic [31:0] ARB_TBL [7] = '{
    32'hAAAA_A065, 32'h30C1_4973, 32'h0000_FF00, 32'hC028_0661,
    32'hFDFF_1054, 32'h5555_FF50, 32'h0821_2562
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cfg_we = 0; clr_we = 0; ei = 0; di = 0; flag_we = 0; iret = 0; ack = 0;
  endtask

  task automatic reset_all(input logic [15:0] c);
    src = '0; clr_we = 1; clr_mask = '1; cfg_we = 1; cfg = c; ei = 1;
    tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL all watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "gie", gie, 0);
    check("R1", "irq", irq, 0);
    check("R1", "pend", pend, 0);
    check("R1", "vec", vec, 0);
    check("R1", "lvl", lvl, 0);
    rst_n = 1;
    tick();

    // R4 R5 R6 R7 arbitration vectors
    for (int k = 0; k < 7; k++) begin
      reset_all(ARB_TBL[k][31:16]);
      src = ARB_TBL[k][15:8];
      tick();
      check("R7", $sformatf("row%0d irq", k), irq, ARB_TBL[k][6]);
      if (ARB_TBL[k][6]) begin
        check("R6", $sformatf("row%0d vec", k), vec, ARB_TBL[k][2:0]);
        check("R5", $sformatf("row%0d lvl", k), lvl, ARB_TBL[k][5:4]);
      end else begin
        check("R4", $sformatf("row%0d disabled pend", k), pend, ARB_TBL[k][15:8]);
      end
    end

    // R2 held line does not re-pend
    reset_all(16'h0000);
    src = 8'h01; tick();
    check("R2", "edge sets", pend, 8'h01);
    clr_we = 1; clr_mask = 8'h01; tick();
    check("R2", "cleared", pend, 8'h00);
    tick();
    check("R2", "held line no reset", pend, 8'h00);

    // R3 same-cycle edge beats clear
    src = 8'h03; tick();
    check("R3", "src1 pends", pend[1], 1);
    src = 8'h01; tick();
    src = 8'h03; clr_we = 1; clr_mask = 8'h02; tick();
    check("R3", "edge beats clear", pend[1], 1);
    clr_we = 1; clr_mask = 8'h02; tick();
    check("R3", "w1c", pend[1], 0);

    // R8 strobes and flag loads
    di = 1; tick();                   check("R8", "di", gie, 0);
    ei = 1; tick();                   check("R8", "ei", gie, 1);
    flag_we = 1; flag_ie = 0; tick(); check("R8", "flag 0", gie, 0);
    flag_we = 1; flag_ie = 1; tick(); check("R8", "flag 1", gie, 1);

    // R9 restore from popped flags
    iret = 1; iret_ie = 0; tick();    check("R9", "iret 0", gie, 0);
    iret = 1; iret_ie = 1; tick();    check("R9", "iret 1", gie, 1);

    // R11 clear beats set
    ei = 1; di = 1; tick();           check("R11", "ei+di", gie, 0);
    ei = 1; flag_we = 1; flag_ie = 0; tick();
    check("R11", "ei+flag0", gie, 0);

    // R10 acknowledge
    reset_all(16'h0030);              // src2 tier 3
    src = 8'h04; tick();
    check("R10", "irq before ack", irq, 1);
    check("R10", "vec before ack", vec, 2);
    ack = 1; tick();
    check("R10", "ack gie", gie, 0);
    check("R10", "ack irq", irq, 0);
    check("R10", "ack pend", pend[2], 0);
    reset_all(16'h0030);
    ack = 1; tick();
    check("R10", "ack idle gie", gie, 1);

    // R12 hold then re-arbitrate
    reset_all(16'h0043);              // src0 tier 3, src3 tier 1
    src = 8'h08; tick();
    check("R12", "first vec", vec, 3);
    check("R12", "first lvl", lvl, 1);
    src = 8'h09; tick();
    check("R12", "held irq", irq, 1);
    check("R12", "held vec", vec, 3);
    check("R12", "new pend", pend[0], 1);
    clr_we = 1; clr_mask = 8'h08; tick();
    check("R12", "gap", irq, 0);
    tick();
    check("R12", "rearb irq", irq, 1);
    check("R12", "rearb vec", vec, 0);
    check("R12", "rearb lvl", lvl, 3);

    // R7 enable gates request
    di = 1; tick();
    check("R7", "gie off irq", irq, 0);
    ei = 1; tick();
    check("R7", "gie on irq", irq, 1);
    check("R7", "gie on vec", vec, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule